// File: doc/BRIEF.md
# Multiplicative Boost Frequency Governor

The governor turns activity monitor events into a target clock frequency. Each accepted event carries an averaged activity count and may flag an upper or a lower watermark crossing. The target is the averaged activity frequency, scaled by a sustain factor derived from the upper threshold, plus a boost term. The boost grows multiplicatively on upper crossings and decays multiplicatively on lower crossings.

The block also computes the values a monitor needs for its next sampling window. These are the upper and lower watermarks, derived from a reference frequency, the sampling period and the percentage thresholds, and two average-band watermarks around the latest average count. It drives the two watermark enable bits, which are withdrawn at the boost saturation points.

All multiplications and divisions run one after another on a single shared shift-based unit. The block is busy for a few hundred cycles after an event. It then pulses `done_o` once, when every output is valid. Events that arrive while it is busy are dropped.

Top module: `boost_governor`

## Requirements
- R1: After reset the boost, target and all four watermark outputs are 0, both enables are 1, and busy_o and done_o are 0.
- R2: On an accepted event with up_i=1, the boost becomes step_i + floor(boost*up_coef_i/100) and both enables are set to 1, unless R3 applies.
- R3: If the R2 sum is greater than or equal to max_freq_i, the boost becomes max_freq_i, up_en_o becomes 0 and down_en_o becomes 1. The two enables are never both 0.
- R4: On an accepted event with down_i=1 and up_i=0, the boost becomes floor(boost*down_coef_i/100) and both enables are set to 1. If that result is below floor(step_i/2), the boost becomes 0, down_en_o becomes 0 and up_en_o becomes 1. A result equal to floor(step_i/2) is kept.
- R5: When up_i and down_i are both 1, only the up rule applies. When both are 0, the boost and the enables keep their values.
- R6: target_o = floor(avg_freq * floor(10000/up_eff) / 100) + boost, where up_eff is the effective upper threshold of R10.
- R7: avg_freq is floor(avg/period) when mode_i=0 (frequency sampling) and floor(avg*cur_freq_i/(mon_freq_i*period)) when mode_i=1 (load sampling). Here avg is the avg_count_i captured with the event.
- R8: up_wm_o = floor(f*period*up_eff/100) and down_wm_o = floor(f*period*down_eff/100), with f = cur_freq_i when mode_i=0 and f = mon_freq_i when mode_i=1.
- R9: avg_up_wm_o = avg + band_i. avg_down_wm_o = avg - band_i when avg > band_i, and 0 otherwise.
- R10: The effective thresholds are down_eff = min(down_thr_i,100) and up_eff = max(min(up_thr_i,100), down_eff, 1). A period_i of 0 is used as 1.
- R11: An event is accepted only when busy_o is 0. busy_o is 1 from the cycle after acceptance until the result is ready. done_o is then 1 for exactly one cycle, with busy_o 0 and all outputs valid.
- R12: An event raised while busy_o is 1 has no effect on the boost, the enables or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Event strobe, one cycle |
| up_i | input | 1 | Upper watermark crossed |
| down_i | input | 1 | Lower watermark crossed |
| avg_count_i | input | VW | Averaged activity count |
| mode_i | input | 1 | 0 frequency sampling, 1 load sampling |
| cur_freq_i | input | VW | Current clock frequency |
| mon_freq_i | input | VW | Monitor clock frequency |
| max_freq_i | input | VW | Boost ceiling |
| period_i | input | PERW | Sampling period |
| up_thr_i | input | PCTW | Upper threshold, percent |
| down_thr_i | input | PCTW | Lower threshold, percent |
| step_i | input | VW | Boost step |
| up_coef_i | input | PCTW | Growth coefficient, percent |
| down_coef_i | input | PCTW | Decay coefficient, percent |
| band_i | input | VW | Average band, in counts |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| target_o | output | VW | Target frequency |
| up_wm_o | output | VW | Upper watermark |
| down_wm_o | output | VW | Lower watermark |
| avg_up_wm_o | output | VW | Upper average watermark |
| avg_down_wm_o | output | VW | Lower average watermark |
| up_en_o | output | 1 | Keep upper watermark active |
| down_en_o | output | 1 | Keep lower watermark active |

## Verification
A run of upper events walks the boost from zero through its growth steps into the ceiling. A following run of lower events decays it to the floor. Together these separate the growth formula, the clamp, the half-step collapse and the enable withdrawal at each end. A step whose decayed value lands exactly on half a step tells a strict comparison from an inclusive one. Events with both flags set, and with neither, expose the priority and the hold behaviour. An event raised mid-computation shows that nothing leaks in.

Both sampling modes are run with the same thresholds, so that the choice of average-frequency formula and watermark reference frequency is visible. Out-of-range, inverted and zero thresholds, together with a zero period, exercise each clamp of the threshold rules. An average below the band checks the floored lower average watermark.

// File: rtl/gov_pkg.sv
package gov_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_BMUL, ST_BDIV, ST_FMUL, ST_UMUL, ST_UDIV, ST_WMUL,
    ST_WDIV, ST_NMUL, ST_DMUL, ST_ADIV, ST_SDIV, ST_TMUL, ST_TDIV
  } gov_state_e;

  typedef enum logic {MDU_MUL = 1'b0, MDU_DIV = 1'b1} mdu_op_e;

  localparam int unsigned PCT_SCALE   = 100;
  localparam int unsigned SUSTAIN_NUM = 10000;
endpackage

// File: rtl/gov_mdu.sv
module gov_mdu
  import gov_pkg::*;
#(
  parameter int unsigned MW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  mdu_op_e       op_i,
  input  logic [MW-1:0] a_i,
  input  logic [MW-1:0] b_i,
  output logic          done_o,
  output logic [MW-1:0] res_o
);
  localparam int unsigned CNTW = $clog2(MW);

  logic            run_q, done_q;
  mdu_op_e         op_q;
  logic [MW-1:0]   acc_q, x_q, y_q;
  logic [CNTW-1:0] cnt_q;
  logic [MW:0]     shl;
  logic [MW-1:0]   dif;
  logic            ge;

  // restoring divide step: remainder in acc_q, quotient shifts through x_q
  always_comb begin
    shl = {acc_q, x_q[MW-1]};
    ge  = shl >= {1'b0, y_q};
    dif = shl[MW-1:0] - y_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      op_q   <= MDU_MUL;
      acc_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q <= 1'b1;
        op_q  <= op_i;
        acc_q <= '0;
        x_q   <= a_i;
        y_q   <= b_i;
        cnt_q <= '0;
      end else if (run_q) begin
        if (op_q == MDU_MUL) begin
          if (y_q[0]) acc_q <= acc_q + x_q;
          x_q <= x_q << 1;
          y_q <= y_q >> 1;
        end else begin
          acc_q <= ge ? dif : shl[MW-1:0];
          x_q   <= {x_q[MW-2:0], ge};
        end
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNTW'(MW - 1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign res_o  = (op_q == MDU_DIV) ? x_q : acc_q;

  // R11
  mdu_done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R11
  mdu_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !run_q);
endmodule

// File: rtl/gov_thresh.sv
module gov_thresh #(
  parameter int unsigned PCTW = 8,
  parameter int unsigned PERW = 8
) (
  input  logic [PCTW-1:0] up_thr_i,
  input  logic [PCTW-1:0] dn_thr_i,
  input  logic [PERW-1:0] period_i,
  output logic [PCTW-1:0] up_eff_o,
  output logic [PCTW-1:0] dn_eff_o,
  output logic [PERW-1:0] per_eff_o
);
  localparam logic [PCTW-1:0] PCT_MAX = PCTW'(100);
  localparam logic [PCTW-1:0] PCT_ONE = PCTW'(1);

  logic [PCTW-1:0] up_lim;

  always_comb begin
    dn_eff_o = (dn_thr_i > PCT_MAX) ? PCT_MAX : dn_thr_i;
    up_lim   = (up_thr_i > PCT_MAX) ? PCT_MAX : up_thr_i;
    up_eff_o = (up_lim < dn_eff_o) ? dn_eff_o : up_lim;
    if (up_eff_o < PCT_ONE) up_eff_o = PCT_ONE;
    per_eff_o = (period_i == '0) ? PERW'(1) : period_i;
  end
endmodule

// File: rtl/gov_boost_rule.sv
module gov_boost_rule #(
  parameter int unsigned VW = 32,
  parameter int unsigned MW = 64
) (
  input  logic          is_up_i,
  input  logic [MW-1:0] q_i,
  input  logic [VW-1:0] step_i,
  input  logic [VW-1:0] max_i,
  output logic [VW-1:0] boost_o,
  output logic          up_en_o,
  output logic          dn_en_o
);
  logic [MW-1:0] step_w, max_w, sum, half;

  always_comb begin
    step_w  = {{(MW-VW){1'b0}}, step_i};
    max_w   = {{(MW-VW){1'b0}}, max_i};
    sum     = q_i + step_w;
    half    = step_w >> 1;
    up_en_o = 1'b1;
    dn_en_o = 1'b1;
    if (is_up_i) begin
      if (sum >= max_w) begin
        boost_o = max_i;
        up_en_o = 1'b0;
      end else begin
        boost_o = sum[VW-1:0];
      end
    end else if (q_i < half) begin
      boost_o = '0;
      dn_en_o = 1'b0;
    end else begin
      boost_o = q_i[VW-1:0];
    end
  end
endmodule

// File: rtl/boost_governor.sv
module boost_governor
  import gov_pkg::*;
#(
  parameter int unsigned VW   = 32,
  parameter int unsigned PCTW = 8,
  parameter int unsigned PERW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            evt_i,
  input  logic            up_i,
  input  logic            down_i,
  input  logic [VW-1:0]   avg_count_i,
  input  logic            mode_i,
  input  logic [VW-1:0]   cur_freq_i,
  input  logic [VW-1:0]   mon_freq_i,
  input  logic [VW-1:0]   max_freq_i,
  input  logic [PERW-1:0] period_i,
  input  logic [PCTW-1:0] up_thr_i,
  input  logic [PCTW-1:0] down_thr_i,
  input  logic [VW-1:0]   step_i,
  input  logic [PCTW-1:0] up_coef_i,
  input  logic [PCTW-1:0] down_coef_i,
  input  logic [VW-1:0]   band_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [VW-1:0]   target_o,
  output logic [VW-1:0]   up_wm_o,
  output logic [VW-1:0]   down_wm_o,
  output logic [VW-1:0]   avg_up_wm_o,
  output logic [VW-1:0]   avg_down_wm_o,
  output logic            up_en_o,
  output logic            down_en_o
);
  localparam int unsigned MW = 2 * VW;
  localparam logic [MW-1:0] C_ONE  = MW'(1);
  localparam logic [MW-1:0] C_PCT  = MW'(PCT_SCALE);
  localparam logic [MW-1:0] C_SUS  = MW'(SUSTAIN_NUM);

  gov_state_e    state_q;
  logic          issued_q, done_q;
  logic          up_q, dn_q;
  logic [VW-1:0] avg_q, boost_q, tgt_q, uwm_q, dwm_q, auw_q, adw_q;
  logic          up_en_q, dn_en_q;
  logic [MW-1:0] prod_q, fp_q, den_q, avgf_q, sus_q;

  logic [PCTW-1:0] up_eff, dn_eff;
  logic [PERW-1:0] per_eff;

  logic          mdu_start, mdu_done;
  mdu_op_e       mdu_op;
  logic [MW-1:0] mdu_a, mdu_b, mdu_res;

  logic [VW-1:0] rule_boost;
  logic          rule_up_en, rule_dn_en;
  logic [VW-1:0] ref_freq;

  gov_thresh #(.PCTW(PCTW), .PERW(PERW)) u_thresh (
    .up_thr_i  (up_thr_i),
    .dn_thr_i  (down_thr_i),
    .period_i  (period_i),
    .up_eff_o  (up_eff),
    .dn_eff_o  (dn_eff),
    .per_eff_o (per_eff)
  );

  gov_mdu #(.MW(MW)) u_mdu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (mdu_start),
    .op_i    (mdu_op),
    .a_i     (mdu_a),
    .b_i     (mdu_b),
    .done_o  (mdu_done),
    .res_o   (mdu_res)
  );

  gov_boost_rule #(.VW(VW), .MW(MW)) u_rule (
    .is_up_i (up_q),
    .q_i     (mdu_res),
    .step_i  (step_i),
    .max_i   (max_freq_i),
    .boost_o (rule_boost),
    .up_en_o (rule_up_en),
    .dn_en_o (rule_dn_en)
  );

  function automatic logic [MW-1:0] zv(input logic [VW-1:0] v);
    return {{(MW-VW){1'b0}}, v};
  endfunction

  function automatic logic [MW-1:0] zp(input logic [PCTW-1:0] v);
    return {{(MW-PCTW){1'b0}}, v};
  endfunction

  function automatic logic [MW-1:0] zr(input logic [PERW-1:0] v);
    return {{(MW-PERW){1'b0}}, v};
  endfunction

  function automatic gov_state_e next_st(input gov_state_e s);
    case (s)
      ST_BMUL: return ST_BDIV;
      ST_BDIV: return ST_FMUL;
      ST_FMUL: return ST_UMUL;
      ST_UMUL: return ST_UDIV;
      ST_UDIV: return ST_WMUL;
      ST_WMUL: return ST_WDIV;
      ST_WDIV: return ST_NMUL;
      ST_NMUL: return ST_DMUL;
      ST_DMUL: return ST_ADIV;
      ST_ADIV: return ST_SDIV;
      ST_SDIV: return ST_TMUL;
      ST_TMUL: return ST_TDIV;
      default: return ST_IDLE;
    endcase
  endfunction

  assign ref_freq  = mode_i ? mon_freq_i : cur_freq_i;
  assign mdu_start = (state_q != ST_IDLE) && !issued_q;

  // operand routing per micro-step
  always_comb begin
    mdu_op = MDU_MUL;
    mdu_a  = '0;
    mdu_b  = '0;
    case (state_q)
      ST_BMUL: begin mdu_a = zv(boost_q); mdu_b = up_q ? zp(up_coef_i) : zp(down_coef_i); end
      ST_BDIV: begin mdu_op = MDU_DIV; mdu_a = prod_q; mdu_b = C_PCT; end
      ST_FMUL: begin mdu_a = zv(ref_freq); mdu_b = zr(per_eff); end
      ST_UMUL: begin mdu_a = fp_q; mdu_b = zp(up_eff); end
      ST_UDIV: begin mdu_op = MDU_DIV; mdu_a = prod_q; mdu_b = C_PCT; end
      ST_WMUL: begin mdu_a = fp_q; mdu_b = zp(dn_eff); end
      ST_WDIV: begin mdu_op = MDU_DIV; mdu_a = prod_q; mdu_b = C_PCT; end
      ST_NMUL: begin mdu_a = zv(avg_q); mdu_b = mode_i ? zv(cur_freq_i) : C_ONE; end
      ST_DMUL: begin mdu_a = zr(per_eff); mdu_b = mode_i ? zv(mon_freq_i) : C_ONE; end
      ST_ADIV: begin mdu_op = MDU_DIV; mdu_a = prod_q; mdu_b = den_q; end
      ST_SDIV: begin mdu_op = MDU_DIV; mdu_a = C_SUS; mdu_b = zp(up_eff); end
      ST_TMUL: begin mdu_a = avgf_q; mdu_b = sus_q; end
      ST_TDIV: begin mdu_op = MDU_DIV; mdu_a = prod_q; mdu_b = C_PCT; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      done_q   <= 1'b0;
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      avg_q    <= '0;
      boost_q  <= '0;
      tgt_q    <= '0;
      uwm_q    <= '0;
      dwm_q    <= '0;
      auw_q    <= '0;
      adw_q    <= '0;
      up_en_q  <= 1'b1;
      dn_en_q  <= 1'b1;
      prod_q   <= '0;
      fp_q     <= '0;
      den_q    <= '0;
      avgf_q   <= '0;
      sus_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (evt_i) begin
          up_q    <= up_i;
          dn_q    <= down_i;
          avg_q   <= avg_count_i;
          auw_q   <= avg_count_i + band_i;
          adw_q   <= (avg_count_i > band_i) ? (avg_count_i - band_i) : '0;
          state_q <= (up_i || down_i) ? ST_BMUL : ST_FMUL;
        end
      end else begin
        if (mdu_start) issued_q <= 1'b1;
        if (mdu_done) begin
          issued_q <= 1'b0;
          state_q  <= next_st(state_q);
          case (state_q)
            ST_BDIV: begin
              boost_q <= rule_boost;
              up_en_q <= rule_up_en;
              dn_en_q <= rule_dn_en;
            end
            ST_FMUL: fp_q   <= mdu_res;
            ST_UDIV: uwm_q  <= mdu_res[VW-1:0];
            ST_WDIV: dwm_q  <= mdu_res[VW-1:0];
            ST_DMUL: den_q  <= mdu_res;
            ST_ADIV: avgf_q <= mdu_res;
            ST_SDIV: sus_q  <= mdu_res;
            ST_TDIV: begin
              tgt_q  <= mdu_res[VW-1:0] + boost_q;
              done_q <= 1'b1;
            end
            default: prod_q <= mdu_res;
          endcase
        end
      end
    end
  end

  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign target_o      = tgt_q;
  assign up_wm_o       = uwm_q;
  assign down_wm_o     = dwm_q;
  assign avg_up_wm_o   = auw_q;
  assign avg_down_wm_o = adw_q;
  assign up_en_o       = up_en_q;
  assign down_en_o     = dn_en_q;

  // R11
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && evt_i) |=> busy_o);

  // R11
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE) && !issued_q);

  // R12
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && evt_i) |=> $stable(avg_q) && $stable(up_q) && $stable(dn_q));

  // R3
  up_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(up_en_q) |-> (boost_q == max_freq_i) && dn_en_q);

  // R4
  down_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dn_en_q) |-> (boost_q == '0) && up_en_q);

  // R3
  en_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_en_q || dn_en_q);

  // R10
  thr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_eff >= dn_eff) && (up_eff <= PCTW'(100)) && (up_eff != '0) && (per_eff != '0));
endmodule

// File: tb/boost_governor_tb.sv
module boost_governor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt = 1'b0, up = 1'b0, dn = 1'b0;
  logic [31:0] avg_cnt = '0;
  logic        mode = 1'b0;
  logic [31:0] cur = 32'd100000, mon = 32'd1000, maxf = 32'd200000;
  logic [7:0]  period = 8'd12, upt = 8'd60, dnt = 8'd40;
  logic [31:0] step = 32'd16000;
  logic [7:0]  upc = 8'd200, dnc = 8'd50;
  logic [31:0] band = 32'd14400;

  logic        busy_o, done_o, up_en_o, down_en_o;
  logic [31:0] target_o, up_wm_o, down_wm_o, avg_up_wm_o, avg_down_wm_o;

  always #5 clk = ~clk;

  boost_governor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .up_i(up), .down_i(dn),
    .avg_count_i(avg_cnt), .mode_i(mode), .cur_freq_i(cur), .mon_freq_i(mon),
    .max_freq_i(maxf), .period_i(period), .up_thr_i(upt), .down_thr_i(dnt),
    .step_i(step), .up_coef_i(upc), .down_coef_i(dnc), .band_i(band),
    .busy_o(busy_o), .done_o(done_o), .target_o(target_o), .up_wm_o(up_wm_o),
    .down_wm_o(down_wm_o), .avg_up_wm_o(avg_up_wm_o),
    .avg_down_wm_o(avg_down_wm_o), .up_en_o(up_en_o), .down_en_o(down_en_o)
  );

  int n_chk = 0, n_fail = 0;
  bit chk_on = 1'b0, finished = 1'b0;
  longint cyc = 0;
  localparam longint MASK = 64'hffff_ffff;

  // pending model state
  longint m_boost = 0, m_ue = 1, m_de = 1, m_tgt = 0;
  longint m_uwm = 0, m_dwm = 0, m_auw = 0, m_adw = 0;
  // committed (visible) state
  longint c_ue = 1, c_de = 1, c_tgt = 0, c_uwm = 0, c_dwm = 0, c_auw = 0, c_adw = 0;

  task automatic chk(input string req, input longint act, input longint exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      summary();
    end
  end

  // per-clock comparison of idle outputs against the committed model
  always @(negedge clk) begin
    if (chk_on && rst_n && !busy_o && !done_o) begin
      chk("R12", longint'(target_o), c_tgt, "idle target");
      chk("R12", longint'(up_en_o), c_ue, "idle up_en");
      chk("R12", longint'(down_en_o), c_de, "idle down_en");
      chk("R12", longint'(up_wm_o), c_uwm, "idle up_wm");
    end
  end

  task automatic model(input bit u, input bit d, input longint avg);
    longint de_e, ue_e, per, f, q, s, avgf, sus;
    de_e = (dnt > 100) ? 100 : longint'(dnt);
    ue_e = (upt > 100) ? 100 : longint'(upt);
    if (ue_e < de_e) ue_e = de_e;
    if (ue_e < 1) ue_e = 1;
    per = (period == 0) ? 1 : longint'(period);
    if (u) begin
      q = m_boost * longint'(upc) / 100;
      s = longint'(step) + q;
      if (s >= longint'(maxf)) begin m_boost = maxf; m_ue = 0; m_de = 1; end
      else begin m_boost = s; m_ue = 1; m_de = 1; end
    end else if (d) begin
      q = m_boost * longint'(dnc) / 100;
      if (q < longint'(step) / 2) begin m_boost = 0; m_de = 0; m_ue = 1; end
      else begin m_boost = q; m_ue = 1; m_de = 1; end
    end
    f = mode ? longint'(mon) : longint'(cur);
    m_uwm = (f * per * ue_e / 100) & MASK;
    m_dwm = (f * per * de_e / 100) & MASK;
    m_auw = (avg + longint'(band)) & MASK;
    m_adw = (avg > longint'(band)) ? avg - longint'(band) : 0;
    avgf = mode ? (avg * longint'(cur)) / (longint'(mon) * per) : avg / per;
    sus = 10000 / ue_e;
    m_tgt = (avgf * sus / 100 + m_boost) & MASK;
  endtask

  task automatic fire(input bit u, input bit d, input longint avg, input bit poke,
                      input string rb, input string rt);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    evt = 1'b1; up = u; dn = d; avg_cnt = avg[31:0];
    @(negedge clk);
    evt = 1'b0; up = 1'b0; dn = 1'b0;
    model(u, d, avg);
    chk("R11", longint'(busy_o), 1, "busy after accept");
    if (poke) begin
      repeat (5) @(negedge clk);
      evt = 1'b1; up = 1'b1; dn = 1'b0; avg_cnt = 32'd999;
      @(negedge clk);
      evt = 1'b0; up = 1'b0;
    end
    while (!done_o) @(negedge clk);
    chk("R11", longint'(busy_o), 0, "busy at done");
    chk(rb, longint'(up_en_o), m_ue, "up_en");
    chk(rb, longint'(down_en_o), m_de, "down_en");
    chk(rt, longint'(target_o), m_tgt, "target");
    chk("R8", longint'(up_wm_o), m_uwm, "up_wm");
    chk("R8", longint'(down_wm_o), m_dwm, "down_wm");
    chk("R9", longint'(avg_up_wm_o), m_auw, "avg_up_wm");
    chk("R9", longint'(avg_down_wm_o), m_adw, "avg_down_wm");
    c_ue = m_ue; c_de = m_de; c_tgt = m_tgt; c_uwm = m_uwm;
    c_dwm = m_dwm; c_auw = m_auw; c_adw = m_adw;
    @(negedge clk);
    chk("R11", longint'(done_o), 0, "done single pulse");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", longint'(target_o), 0, "reset target");
    chk("R1", longint'(up_wm_o) + longint'(down_wm_o), 0, "reset wm");
    chk("R1", longint'(avg_up_wm_o) + longint'(avg_down_wm_o), 0, "reset avg wm");
    chk("R1", longint'(up_en_o), 1, "reset up_en");
    chk("R1", longint'(down_en_o), 1, "reset down_en");
    chk("R1", longint'(busy_o) + longint'(done_o), 0, "reset busy/done");
    rst_n = 1'b1;
    chk_on = 1'b1;

    // R5 neither flag, R6/R7 frequency mode
    fire(1'b0, 1'b0, 600000, 1'b0, "R5", "R6");
    chk("R7", longint'(target_o), 83000, "freq-mode target");

    // R2 growth, R3 clamp
    fire(1'b1, 1'b0, 600000, 1'b0, "R2", "R6");
    fire(1'b1, 1'b0, 600000, 1'b0, "R2", "R6");
    fire(1'b1, 1'b0, 600000, 1'b0, "R2", "R6");
    fire(1'b1, 1'b0, 600000, 1'b0, "R3", "R6");
    chk("R3", longint'(up_en_o), 0, "clamped up_en");
    fire(1'b1, 1'b0, 600000, 1'b0, "R3", "R6");

    // R4 decay and collapse
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");
    chk("R4", longint'(down_en_o), 0, "collapsed down_en");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");

    // R2 re-enable; R4 exact half step kept, then collapse
    fire(1'b1, 1'b0, 600000, 1'b0, "R2", "R6");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");
    chk("R4", longint'(target_o), 83000 + 8000, "half-step kept");
    fire(1'b0, 1'b1, 600000, 1'b0, "R4", "R6");

    // R5 both flags: up wins
    fire(1'b1, 1'b1, 600000, 1'b0, "R5", "R6");
    chk("R5", longint'(target_o), 83000 + 16000, "up priority");

    // R12 event during busy ignored
    fire(1'b0, 1'b0, 600000, 1'b1, "R12", "R12");
    fire(1'b0, 1'b0, 600000, 1'b0, "R12", "R12");

    // R7/R8 load mode, R9 avg below band
    mode = 1'b1;
    fire(1'b0, 1'b0, 6000, 1'b0, "R7", "R7");
    chk("R7", longint'(up_wm_o), 7200, "load-mode up_wm");
    chk("R9", longint'(avg_down_wm_o), 0, "avg down floor");

    // R10 threshold clamps
    upt = 8'd150;
    fire(1'b0, 1'b0, 6000, 1'b0, "R10", "R10");
    upt = 8'd30; dnt = 8'd50;
    fire(1'b0, 1'b0, 6000, 1'b0, "R10", "R10");
    upt = 8'd0; dnt = 8'd120;
    fire(1'b0, 1'b0, 6000, 1'b0, "R10", "R10");
    dnt = 8'd0;
    fire(1'b0, 1'b0, 6000, 1'b0, "R10", "R10");
    upt = 8'd60; dnt = 8'd40; period = 8'd0; mode = 1'b0;
    fire(1'b1, 1'b0, 50000, 1'b0, "R10", "R10");

    repeat (4) @(negedge clk);
    summary();
  end
endmodule